// File: doc/BRIEF.md
# Reset Exception Sequencer

This block takes a processor core through its reset exception. It watches two sources: an active-low reset pin from outside the chip, and a one-cycle overflow pulse from the watchdog. It keeps the core in reset for as long as a valid reset lasts. The pin must stay low for a minimum number of clock states before it counts as a reset. Once the pin is released, the block runs the start-up sequence in a fixed order:

1. It writes the initial status flags.
2. It reads the 32-bit start address from the vector table as two 16-bit memory reads.
3. It loads the program counter.
4. It grants execution.

While reset is active or the sequence is running, no other exception can be taken. The core's own logic, the interrupt controller and the watchdog counter sit outside this block. They see the sequencer only through its strobes and enables.

The synchronous active-low `rst_n` is the power-on reset. It leaves the block in the held state, exactly as a qualified pin reset would. The sequence therefore starts as soon as the synchronised pin reads high.

Top module: `reset_seq`

## Requirements
- R1: After `rst_n`, and while the pin stays low, `core_rst` is 1 and both `run_en` and `mem_req` are 0. Once the pin reads high, the sequence runs to completion without any further reset pulse.
- R2: The pin passes through two synchroniser flops and is then counted. If it stays low for at least MIN_LOW_STATES (default 20) cycles, the block enters the held state: `core_rst` is 1 and `run_en` is 0.
- R3: A low pulse shorter than MIN_LOW_STATES cycles has no effect. While running, `core_rst` stays 0, `run_en` stays 1 and no memory read is issued.
- R4: The sequence starts only after the synchronised pin reads high. While the pin is held low, `flag_wr` and `mem_req` stay 0 and `icm_clear` stays 1.
- R5: The first step of the sequence is a one-cycle `flag_wr` carrying `flag_trace`=0, `flag_exr_imask`=all ones and `flag_ccr_imask`=1. During this cycle `mem_req` is 0, and `icm_clear` is still 1.
- R6: The vector is fetched as two 16-bit reads. The first read, at VEC_BASE (default 0), returns bits 31:16. The second, at VEC_BASE+2, returns bits 15:0. `mem_req` and `mem_addr` hold steady until `mem_ack` is seen high at a clock edge.
- R7: `pc_load` is a one-cycle pulse that follows the second acknowledge, with `pc_value` = {upper half, lower half}. `run_en` rises in the cycle after `pc_load` and never before it. A missing acknowledge stalls the sequence indefinitely.
- R8: A single-cycle `wdt_ovf` pulse causes the same reset as the pin, with no width check. `core_rst` is 1 in the cycle after the pulse.
- R9: A qualified reset or a watchdog pulse during the vector fetch aborts the fetch. `mem_req` drops, the block returns to the held state, and no `pc_load` is produced. On the next release the fetch starts again from the upper half.
- R10: `exc_take` follows `exc_req` only while `run_en` is 1 and no reset is arriving in the same cycle. Reset always wins over a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| exc_req | input | 1 | Pending lower-priority exception request |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | HALF_W | Memory read data |
| core_rst | output | 1 | Holds the core and peripherals in reset |
| run_en | output | 1 | Instruction execution allowed |
| icm_clear | output | 1 | Forces interrupt control mode to 0 |
| flag_wr | output | 1 | Status flag initialisation strobe |
| flag_trace | output | 1 | Trace flag value |
| flag_exr_imask | output | IMASK_W | Extended-register interrupt mask value |
| flag_ccr_imask | output | 1 | Condition-code interrupt mask value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 2*HALF_W | Vector value for the program counter |
| exc_take | output | 1 | Lower-priority exception granted |

## Verification
The bench sweeps pin pulses around the threshold: 19, 20 and 21 cycles, together with very short and very long pulses. A counter that is off by one would either reset on a 19-cycle glitch or ignore a legal 20-cycle pulse.

It withholds the acknowledge for a long stretch. A sequencer that does not wait would load a wrong program counter or raise `run_en` early. It also fires the watchdog in the middle of the fetch, where a missing abort would show up as a stray `pc_load`, or as a restart that begins with the lower half.

Finally, it raises an exception request in the same cycle as a watchdog pulse. A priority gate that is wrong would grant the exception just as reset arrives.

// File: rtl/rsq_pkg.sv
// Package: shared state encodings for the reset exception sequencer.
// Assumes: nothing beyond SystemVerilog packages.
package rsq_pkg;

    // Top-level sequencer states, in sequence order.
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_INIT  = 2'd1,
        SEQ_FETCH = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_t;

    // Phases of the two-part vector read.
    typedef enum logic [1:0] {
        FP_IDLE = 2'd0,
        FP_HI   = 2'd1,
        FP_LO   = 2'd2,
        FP_FIN  = 2'd3
    } fetch_phase_t;

endpackage

// File: rtl/rsq_pin_qual.sv
// Module: rsq_pin_qual
// Synchronises the external reset pin and counts how long it has been low.
// The count saturates at MIN_LOW and clears as soon as the pin reads high.
// Assumes: rst_pin_n may change at any time. While rst_n is low, the
// synchroniser reads "pin low", so the core is never released early.
module rsq_pin_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin_n,
    output logic pin_low_s,
    output logic qualified
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    logic [SYNC_STAGES-1:0] low_sync_q;
    logic [CNT_W-1:0]       low_cnt_q;

    // Synchroniser chain carrying the "pin is low" level.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    low_sync_q[g] <= ~rst_pin_n;
                end else begin
                    low_sync_q[g] <= low_sync_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign pin_low_s = low_sync_q[SYNC_STAGES-1];

    // Saturating count of consecutive synchronised low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!pin_low_s) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_MAX) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign qualified = (low_cnt_q == CNT_MAX);

    // A high pin reading forgets any partial low time.
    assert_short_low_forgotten_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_low_s |=> !qualified);

    // Qualification needs the pin to have been low in the previous cycle too.
    assert_qual_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (qualified && $past(rst_n)) |-> $past(pin_low_s));

endmodule

// File: rtl/rsq_vec_fetch.sv
// Module: rsq_vec_fetch
// Reads the reset vector as two half-width reads, upper half first, over a
// request/acknowledge interface. It then presents the joined value, with a
// one-cycle done pulse.
// Assumes: a read completes in the cycle where mem_req and mem_ack are both
// high at the clock edge. Abort always wins over every other input.
module rsq_vec_fetch
    import rsq_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                HALF_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                abort,
    input  logic                mem_ack,
    input  logic [HALF_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                done,
    output logic [2*HALF_W-1:0] vec_value
);
    localparam logic [ADDR_W-1:0] LO_OFFSET = ADDR_W'(HALF_W / 8);

    fetch_phase_t        phase_q;
    logic [HALF_W-1:0]   hi_q;
    logic [2*HALF_W-1:0] vec_q;

    // Phase register: idle, upper read, lower read, done.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase_q <= FP_IDLE;
        end else begin
            unique case (phase_q)
                FP_IDLE: if (start)   phase_q <= FP_HI;
                FP_HI:   if (mem_ack) phase_q <= FP_LO;
                FP_LO:   if (mem_ack) phase_q <= FP_FIN;
                FP_FIN:               phase_q <= FP_IDLE;
                default:              phase_q <= FP_IDLE;
            endcase
        end
    end

    // Data capture for the upper half and the joined vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            vec_q <= '0;
        end else if (!abort && mem_ack) begin
            if (phase_q == FP_HI) hi_q  <= mem_rdata;
            if (phase_q == FP_LO) vec_q <= {hi_q, mem_rdata};
        end
    end

    assign mem_req   = (phase_q == FP_HI) || (phase_q == FP_LO);
    assign mem_addr  = (phase_q == FP_LO) ? (VEC_BASE + LO_OFFSET) : VEC_BASE;
    assign done      = (phase_q == FP_FIN);
    assign vec_value = vec_q;

    // A pending request keeps its address until acknowledged.
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));

    // Done only follows an acknowledged lower-half read.
    assert_done_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(rst_n)) |-> $past(mem_req && mem_ack));

endmodule

// File: rtl/rsq_core_ctl.sv
// Module: rsq_core_ctl
// Turns the sequencer state into the core-facing controls: reset hold,
// run enable, the flag initialisation strobe and its values, clearing of
// the interrupt mode, and the gate that grants lower-priority exceptions.
// Assumes: state comes from a register. reset_in is high in any cycle
// where a reset is arriving.
module rsq_core_ctl
    import rsq_pkg::*;
#(
    parameter int IMASK_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state,
    input  logic               reset_in,
    input  logic               exc_req,
    output logic               core_rst,
    output logic               run_en,
    output logic               icm_clear,
    output logic               flag_wr,
    output logic               flag_trace,
    output logic [IMASK_W-1:0] flag_exr_imask,
    output logic               flag_ccr_imask,
    output logic               exc_take
);
    // State decode for the core controls.
    always_comb begin
        core_rst  = (state == SEQ_HOLD);
        run_en    = (state == SEQ_RUN);
        icm_clear = (state == SEQ_HOLD) || (state == SEQ_INIT);
        flag_wr   = (state == SEQ_INIT);
    end

    // Initial flag values: trace off, all interrupt masks set.
    always_comb begin
        flag_trace     = 1'b0;
        flag_exr_imask = flag_wr ? '1 : '0;
        flag_ccr_imask = flag_wr;
    end

    // Reset outranks any other exception request.
    always_comb begin
        exc_take = exc_req && run_en && !reset_in;
    end

    // Flag initialisation only ever follows the held state.
    assert_init_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && $past(rst_n)) |-> $past(core_rst));

    // A granted exception is never followed by an immediate reset hold.
    assert_exc_not_during_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> !core_rst);

endmodule

// File: rtl/reset_seq.sv
// Module: reset_seq (top)
// Sequences the reset exception: hold, flag initialisation, vector fetch,
// program counter load, then run. A qualified pin reset or a watchdog pulse
// re-enters the hold from any state, aborting a fetch in progress.
// Assumes: rst_n is a synchronous power-on reset that behaves as a
// qualified reset. wdt_ovf is already synchronous to clk.
module reset_seq
    import rsq_pkg::*;
#(
    parameter int                ADDR_W         = 24,
    parameter int                HALF_W         = 16,
    parameter int                IMASK_W        = 3,
    parameter int                MIN_LOW_STATES = 20,
    parameter int                SYNC_STAGES    = 2,
    parameter logic [ADDR_W-1:0] VEC_BASE       = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_pin_n,
    input  logic                wdt_ovf,
    input  logic                exc_req,
    input  logic                mem_ack,
    input  logic [HALF_W-1:0]   mem_rdata,
    output logic                core_rst,
    output logic                run_en,
    output logic                icm_clear,
    output logic                flag_wr,
    output logic                flag_trace,
    output logic [IMASK_W-1:0]  flag_exr_imask,
    output logic                flag_ccr_imask,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                pc_load,
    output logic [2*HALF_W-1:0] pc_value,
    output logic                exc_take
);
    seq_state_t state_q, state_d;
    logic       pin_low_s, pin_qualified, reset_in, fetch_done;

    rsq_pin_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_LOW     (MIN_LOW_STATES)
    ) pin_qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_pin_n (rst_pin_n),
        .pin_low_s (pin_low_s),
        .qualified (pin_qualified)
    );

    assign reset_in = pin_qualified || wdt_ovf;

    rsq_vec_fetch #(
        .ADDR_W   (ADDR_W),
        .HALF_W   (HALF_W),
        .VEC_BASE (VEC_BASE)
    ) vec_fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state_q == SEQ_INIT && !reset_in),
        .abort     (reset_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (fetch_done),
        .vec_value (pc_value)
    );

    rsq_core_ctl #(
        .IMASK_W (IMASK_W)
    ) core_ctl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .state          (state_q),
        .reset_in       (reset_in),
        .exc_req        (exc_req),
        .core_rst       (core_rst),
        .run_en         (run_en),
        .icm_clear      (icm_clear),
        .flag_wr        (flag_wr),
        .flag_trace     (flag_trace),
        .flag_exr_imask (flag_exr_imask),
        .flag_ccr_imask (flag_ccr_imask),
        .exc_take       (exc_take)
    );

    // Program counter load: fetch finished and no reset arriving.
    assign pc_load = fetch_done && (state_q == SEQ_FETCH) && !reset_in;

    // Next-state logic; an arriving reset overrides every transition.
    always_comb begin
        state_d = state_q;
        if (reset_in) begin
            state_d = SEQ_HOLD;
        end else begin
            unique case (state_q)
                SEQ_HOLD:  if (!pin_low_s) state_d = SEQ_INIT;
                SEQ_INIT:                  state_d = SEQ_FETCH;
                SEQ_FETCH: if (pc_load)    state_d = SEQ_RUN;
                SEQ_RUN:                   state_d = SEQ_RUN;
                default:                   state_d = SEQ_HOLD;
            endcase
        end
    end

    // State register; power-on reset lands in the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_HOLD;
        else        state_q <= state_d;
    end

    // Execution is granted only right after a program counter load.
    assert_run_after_pcload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_en) && $past(rst_n)) |-> $past(pc_load));

    // A watchdog pulse of one cycle is enough to hold the core.
    assert_wdt_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_ovf |=> core_rst);

    // Aborted fetch: a reset during a read drops the request.
    assert_fetch_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && reset_in) |=> (!mem_req && !pc_load));

    // No memory read while flags are being written.
    assert_flags_before_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |-> !mem_req);

    // The core never runs while held in reset.
    assert_hold_blocks_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_qualified && $past(rst_n)) |=> (core_rst && !run_en));

endmodule

// File: tb/reset_seq_tb_top.sv
module reset_seq_tb_top;
    localparam int ADDR_W  = 24;
    localparam int HALF_W  = 16;
    localparam int IMASK_W = 3;
    localparam int N_VEC   = 8;

    // Stimulus table: low length (0 = watchdog pulse instead), expect reset.
    localparam int LOW_LEN [N_VEC] = '{1, 5, 19, 20, 21, 45, 0, 12};
    localparam bit USE_WDT [N_VEC] = '{0, 0, 0, 0, 0, 0, 1, 0};
    localparam bit EXP_RST [N_VEC] = '{0, 0, 0, 1, 1, 1, 1, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin_n = 1'b0;
    logic wdt_ovf = 1'b0;
    logic exc_req = 1'b0;
    logic mem_ack = 1'b0;
    logic [HALF_W-1:0] mem_rdata;
    logic core_rst, run_en, icm_clear, flag_wr, flag_trace, flag_ccr_imask;
    logic [IMASK_W-1:0] flag_exr_imask;
    logic mem_req, pc_load, exc_take;
    logic [ADDR_W-1:0] mem_addr;
    logic [2*HALF_W-1:0] pc_value;

    int checks = 0;
    int fails = 0;
    bit ack_en = 1'b1;
    bit finished = 1'b0;
    logic [HALF_W-1:0] vec_hi = 16'h00AB;
    logic [HALF_W-1:0] vec_lo = 16'h1234;

    bit seen_hold = 0, seen_pcload = 0, prev_pcload = 0;
    int ack_cnt = 0;

    always #4 clk = ~clk;

    reset_seq dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .wdt_ovf(wdt_ovf),
        .exc_req(exc_req), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .core_rst(core_rst), .run_en(run_en), .icm_clear(icm_clear),
        .flag_wr(flag_wr), .flag_trace(flag_trace),
        .flag_exr_imask(flag_exr_imask), .flag_ccr_imask(flag_ccr_imask),
        .mem_req(mem_req), .mem_addr(mem_addr), .pc_load(pc_load),
        .pc_value(pc_value), .exc_take(exc_take)
    );

    assign mem_rdata = (mem_addr == '0) ? vec_hi : vec_lo;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges every other cycle while enabled.
    always @(posedge clk) begin
        #2;
        mem_ack = mem_req && !mem_ack && ack_en;
    end

    // Protocol monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (core_rst) seen_hold = 1;
            if (flag_wr) begin
                chk(flag_trace == 1'b0 && flag_exr_imask == '1 && flag_ccr_imask &&
                    !mem_req && icm_clear, "R5 flag init",
                    {flag_trace, flag_exr_imask, flag_ccr_imask, mem_req},
                    {1'b0, 3'b111, 1'b1, 1'b0});
                ack_cnt = 0;
            end
            if (mem_req && ack_cnt == 0)
                if (mem_addr != '0) chk(0, "R6 upper half first", mem_addr, 0);
            if (mem_req && ack_cnt == 1)
                if (mem_addr != 24'd2) chk(0, "R6 lower half second", mem_addr, 2);
            if (mem_req && mem_ack) ack_cnt++;
            if (pc_load) begin
                seen_pcload = 1;
                chk(pc_value == {vec_hi, vec_lo} && ack_cnt == 2, "R7 pc value",
                    {pc_value, 8'(ack_cnt)}, {vec_hi, vec_lo, 8'd2});
            end
            if (run_en && !prev_pcload && $past(run_en) == 0 && seen_pcload == 0)
                chk(0, "R7 run before pc load", run_en, 0);
            prev_pcload = pc_load;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 200 && !run_en; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit stuck_ok;
        // R1: reset state with pin low
        cycles(3);
        chk(core_rst && !run_en && !mem_req, "R1 during rst_n", {core_rst, run_en, mem_req}, 3'b100);
        rst_n = 1'b1;
        cycles(10);
        chk(core_rst && !run_en && !mem_req, "R1 pin low after rst_n", {core_rst, run_en, mem_req}, 3'b100);
        rst_pin_n = 1'b1;
        wait_run();
        chk(run_en && seen_pcload, "R1 power-on sequence", {run_en, seen_pcload}, 2'b11);

        // Table walk: R2 R3 R8
        for (int k = 0; k < N_VEC; k++) begin
            wait_run();
            vec_hi = 16'h1000 + 16'(k);
            vec_lo = 16'hC000 + 16'(k * 3);
            seen_hold = 0;
            seen_pcload = 0;
            if (USE_WDT[k]) begin
                wdt_ovf = 1'b1; cycles(1); wdt_ovf = 1'b0;
            end else begin
                rst_pin_n = 1'b0; cycles(LOW_LEN[k]); rst_pin_n = 1'b1;
            end
            cycles(40);
            chk(seen_hold == EXP_RST[k], EXP_RST[k] ? "R2/R8 reset taken" : "R3 short pulse ignored",
                seen_hold, EXP_RST[k]);
            chk(seen_pcload == EXP_RST[k] && run_en, "R3 fetch only on reset",
                {seen_pcload, run_en}, {EXP_RST[k], 1'b1});
        end

        // R4: long hold, nothing starts while the pin is low
        wait_run();
        rst_pin_n = 1'b0;
        cycles(25);
        stuck_ok = 1;
        for (int i = 0; i < 40; i++) begin
            if (flag_wr || mem_req || !core_rst || !icm_clear || run_en) stuck_ok = 0;
            @(negedge clk);
        end
        chk(stuck_ok, "R4 held while low", stuck_ok, 1);
        rst_pin_n = 1'b1;
        wait_run();

        // R7: acknowledge withheld stalls the sequence
        ack_en = 0;
        seen_pcload = 0;
        wdt_ovf = 1'b1; cycles(1); wdt_ovf = 1'b0;
        cycles(60);
        chk(!run_en && mem_req && mem_addr == '0 && !seen_pcload, "R7 waits for ack",
            {run_en, mem_req, seen_pcload}, 3'b010);
        ack_en = 1;
        cycles(20);
        chk(run_en && seen_pcload, "R7 completes after ack", {run_en, seen_pcload}, 2'b11);

        // R9: watchdog during fetch aborts and restarts
        ack_en = 0;
        seen_pcload = 0;
        wdt_ovf = 1'b1; cycles(1); wdt_ovf = 1'b0;
        cycles(6);
        chk(mem_req, "R9 fetch in progress", mem_req, 1);
        wdt_ovf = 1'b1; cycles(1); wdt_ovf = 1'b0;
        chk(core_rst && !mem_req, "R9 abort to hold", {core_rst, mem_req}, 2'b10);
        ack_en = 1;
        cycles(30);
        chk(run_en && seen_pcload, "R9 restart completes", {run_en, seen_pcload}, 2'b11);

        // R10: reset wins over a pending exception
        exc_req = 1'b1;
        cycles(1);
        chk(exc_take, "R10 grant while running", exc_take, 1);
        wdt_ovf = 1'b1;
        #1;
        chk(!exc_take, "R10 reset same cycle", exc_take, 0);
        cycles(1);
        wdt_ovf = 1'b0;
        chk(!exc_take && core_rst, "R10 no grant in hold", {exc_take, core_rst}, 2'b01);
        exc_req = 1'b0;
        wait_run();
        chk(run_en, "R10 back to run", run_en, 1);
        finish_run();
    end
endmodule